// File: doc/BRIEF.md
# I2C Bus Target with 7-bit and 10-bit Addressing

This block is the target (responder) side of an I2C bus. It watches SCL and SDA through synchronizers, finds START and STOP conditions, and compares the address phase against a programmed own address. That address is either a plain 7-bit one or a 10-bit one that arrives split over a header byte and a low byte. When addressed for a write, it acknowledges each byte and moves the byte from a private shift register into a receive buffer the host can read. When addressed for a read, it shifts out a byte supplied by the host.

After each data byte it holds SCL low (clock stretching), so that the host has time to empty the receive buffer or supply the next transmit byte. It lets SCL go again only when the host pulses a release input. The bus pins are modelled as open-drain: the block only ever drives a pull-low enable for each line.

Top module: `i2c_tgt_core`

## Requirements
- R1: After reset both pull-low enables, `rx_irq`, `rx_full`, `rx_ovf`, `addr10_hit` and `tx_mode` are 0.
- R2: With `ten_bit_en`=0, an address byte whose upper seven bits equal `own_addr[6:0]` is acknowledged (SDA pulled low during the ninth clock). `own_addr[9:7]` plays no part. A non-matching byte is not acknowledged, and the rest of the transfer up to the next START is ignored: no ACK, no `rx_irq`, `rx_full` unchanged.
- R3: With `ten_bit_en`=1, a header byte `11110`,`own_addr[9:8]`,0 is acknowledged, and then a second byte equal to `own_addr[7:0]` is acknowledged and sets `addr10_hit`. A mismatching second byte is not acknowledged. In this mode a 7-bit style address byte is not acknowledged.
- R4: A received data byte (MSB first) is acknowledged and copied to `rx_data`. The copy sets `rx_full` and gives a one-cycle `rx_irq` pulse. A one-cycle `rx_rd` clears `rx_full`.
- R5: If a data byte completes while `rx_full` is 1, `rx_ovf` is set and stays set until reset. `rx_data` keeps its old byte and no `rx_irq` pulse is given.
- R6: After the ACK clock of a received data byte, or of any byte that leads into or continues a read, `scl_oe` stays 1 until `scl_rel` is pulsed.
- R7: A 7-bit address with R/W=1 is acknowledged and sets `tx_mode`. After `scl_rel`, `tx_byte` is sent MSB first on SDA, and `sda_oe` changes only while SCL is low.
- R8: In 10-bit mode, a repeated START followed by the header byte with R/W=1 is acknowledged and starts a read, but only if the full 10-bit address was matched earlier in the same transaction. Without that earlier match the header is not acknowledged.
- R9: When the controller answers a transmitted byte with NACK, the block releases SDA, clears `tx_mode` and ignores further bytes until the next START.
- R10: A STOP releases both lines and clears `addr10_hit` and `tx_mode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low (clock stretch) |
| sda_oe | output | 1 | Pull SDA low |
| own_addr | input | 10 | Own address; bits 6:0 used in 7-bit mode |
| ten_bit_en | input | 1 | 1 selects 10-bit address matching |
| tx_byte | input | 8 | Byte to send on a read, taken at release |
| scl_rel | input | 1 | Pulse: release a stretched SCL |
| rx_rd | input | 1 | Pulse: host has read `rx_data` |
| rx_data | output | 8 | Receive buffer |
| rx_irq | output | 1 | One-cycle pulse when a byte enters the buffer |
| rx_full | output | 1 | Receive buffer holds an unread byte |
| rx_ovf | output | 1 | Sticky overflow flag |
| addr10_hit | output | 1 | Addressed through a full 10-bit match |
| tx_mode | output | 1 | Addressed for a read |

## Verification
The address matcher is tried with a table of 7-bit cases: a plain match, an off-by-one miss, all-ones and all-zero addresses, a match whose unused upper address bits are set, and a 7-bit byte offered while 10-bit mode is on. Together these separate a correct seven-bit compare from one that includes too many or too few bits, or that ignores the mode. The 10-bit cases pair a good header with a good and a bad low byte, and offer a read header both with and without an earlier match, which tells a real two-stage match from a header-only one. Receive-buffer overflow, a two-byte read ending in NACK, and traffic after that NACK show whether the buffer, stretch and release logic keep their state correctly.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR1,
        ST_ADDR2,
        ST_RX,
        ST_TX
    } tgt_state_e;

    // fixed high part of a 10-bit address header byte
    localparam logic [4:0] HDR10 = 5'b11110;

endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stg_q[s] <= '1;
                end else if (s == 0) begin
                    stg_q[s] <= d;
                end else begin
                    stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/i2c_tgt_cond.sv
module i2c_tgt_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_tgt_addr_match.sv
module i2c_tgt_addr_match
    import i2c_tgt_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] byte_i,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              ten_en,
    input  logic              ten_hit,
    output logic              hit7,
    output logic              hdr_wr,
    output logic              hdr_rd,
    output logic              low_hit
);
    localparam int HI_W = ADDR_W - DATA_W;

    logic hdr_ok;

    always_comb begin
        hit7    = !ten_en && (byte_i[DATA_W-1:1] == own_addr[DATA_W-2:0]);
        hdr_ok  = ten_en && (byte_i[DATA_W-1 -: 5] == HDR10)
                         && (byte_i[HI_W:1] == own_addr[ADDR_W-1 -: HI_W]);
        hdr_wr  = hdr_ok && !byte_i[0];
        hdr_rd  = hdr_ok && byte_i[0] && ten_hit;
        low_hit = ten_en && (byte_i == own_addr[DATA_W-1:0]);
    end
endmodule

// File: rtl/i2c_tgt_core.sv
module i2c_tgt_core
    import i2c_tgt_pkg::*;
#(
    parameter int ADDR_W      = 10,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_oe,
    output logic              sda_oe,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              ten_bit_en,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              scl_rel,
    input  logic              rx_rd,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_irq,
    output logic              rx_full,
    output logic              rx_ovf,
    output logic              addr10_hit,
    output logic              tx_mode
);
    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DATA_W);

    typedef struct packed {
        tgt_state_e        state;
        logic [CNT_W-1:0]  bitcnt;
        logic [DATA_W-2:0] sr;
        logic [DATA_W-2:0] txsr;
        logic [DATA_W-1:0] rx_buf;
        logic              in_ack;
        logic              ack;
        logic              data;
        logic              ten_hit;
        logic              addr10;
        logic              rx_full;
        logic              ovf;
        logic              irq;
        logic              sda_oe;
        logic              scl_oe;
    } core_t;

    core_t core_d, core_q;

    logic [1:0] sync_s;
    logic scl_s, sda_s;
    logic scl_rise, scl_fall, start_det, stop_det;
    logic [DATA_W-1:0] new_byte;
    logic hit7, hdr_wr, hdr_rd, low_hit;

    i2c_tgt_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q(sync_s)
    );
    assign scl_s = sync_s[1];
    assign sda_s = sync_s[0];

    i2c_tgt_cond cond_i (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    assign new_byte = {core_q.sr, sda_s};

    i2c_tgt_addr_match #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) match_i (
        .byte_i(new_byte), .own_addr(own_addr), .ten_en(ten_bit_en),
        .ten_hit(core_q.ten_hit), .hit7(hit7), .hdr_wr(hdr_wr),
        .hdr_rd(hdr_rd), .low_hit(low_hit)
    );

    always_comb begin
        core_d     = core_q;
        core_d.irq = 1'b0;
        if (rx_rd) core_d.rx_full = 1'b0;

        if (start_det) begin
            core_d.state  = ST_ADDR1;
            core_d.bitcnt = '0;
            core_d.in_ack = 1'b0;
            core_d.ack    = 1'b0;
            core_d.data   = 1'b0;
            core_d.sda_oe = 1'b0;
            core_d.scl_oe = 1'b0;
        end else if (stop_det) begin
            core_d.state   = ST_IDLE;
            core_d.in_ack  = 1'b0;
            core_d.sda_oe  = 1'b0;
            core_d.scl_oe  = 1'b0;
            core_d.ten_hit = 1'b0;
            core_d.addr10  = 1'b0;
        end else if (core_q.scl_oe) begin
            // stretched: wait for the host
            if (scl_rel) begin
                core_d.scl_oe = 1'b0;
                if (core_q.state == ST_TX) begin
                    core_d.txsr   = tx_byte[DATA_W-2:0];
                    core_d.sda_oe = !tx_byte[DATA_W-1];
                end
            end
        end else if (core_q.state != ST_IDLE) begin
            if (scl_rise) begin
                if (!core_q.in_ack && core_q.bitcnt < CNT_FULL) begin
                    core_d.sr     = new_byte[DATA_W-2:0];
                    core_d.bitcnt = core_q.bitcnt + 1'b1;
                    if (core_q.bitcnt == CNT_LAST) begin
                        core_d.ack  = 1'b1;
                        core_d.data = 1'b0;
                        case (core_q.state)
                            ST_ADDR1: begin
                                if (hit7)        core_d.state = new_byte[0] ? ST_TX : ST_RX;
                                else if (hdr_wr) core_d.state = ST_ADDR2;
                                else if (hdr_rd) core_d.state = ST_TX;
                                else begin
                                    core_d.state = ST_IDLE;
                                    core_d.ack   = 1'b0;
                                end
                            end
                            ST_ADDR2: begin
                                if (low_hit) begin
                                    core_d.state   = ST_RX;
                                    core_d.ten_hit = 1'b1;
                                    core_d.addr10  = 1'b1;
                                end else begin
                                    core_d.state = ST_IDLE;
                                    core_d.ack   = 1'b0;
                                end
                            end
                            ST_RX: begin
                                core_d.data = 1'b1;
                                if (core_q.rx_full && !rx_rd) begin
                                    core_d.ovf = 1'b1;
                                end else begin
                                    core_d.rx_buf  = new_byte;
                                    core_d.rx_full = 1'b1;
                                    core_d.irq     = 1'b1;
                                end
                            end
                            ST_TX:   core_d.ack = 1'b0;
                            default: core_d.ack = 1'b0;
                        endcase
                    end
                end else if (core_q.in_ack && core_q.state == ST_TX && sda_s) begin
                    // controller NACK ends the read
                    core_d.state  = ST_IDLE;
                    core_d.in_ack = 1'b0;
                end
            end else if (scl_fall) begin
                if (core_q.in_ack) begin
                    core_d.in_ack = 1'b0;
                    core_d.sda_oe = 1'b0;
                    core_d.bitcnt = '0;
                    if (core_q.state == ST_TX || core_q.data) core_d.scl_oe = 1'b1;
                end else if (core_q.bitcnt == CNT_FULL) begin
                    core_d.in_ack = 1'b1;
                    core_d.sda_oe = core_q.ack;
                end else if (core_q.state == ST_TX && core_q.bitcnt != '0) begin
                    core_d.sda_oe = !core_q.txsr[DATA_W-2];
                    core_d.txsr   = core_q.txsr << 1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) core_q <= '0;
        else        core_q <= core_d;
    end

    assign scl_oe     = core_q.scl_oe;
    assign sda_oe     = core_q.sda_oe;
    assign rx_data    = core_q.rx_buf;
    assign rx_irq     = core_q.irq;
    assign rx_full    = core_q.rx_full;
    assign rx_ovf     = core_q.ovf;
    assign addr10_hit = core_q.addr10;
    assign tx_mode    = (core_q.state == ST_TX);
endmodule

// File: rtl/i2c_tgt_core_chk.sv
module i2c_tgt_core_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_i,
    input logic scl_oe,
    input logic sda_oe,
    input logic scl_rel,
    input logic rx_irq,
    input logic rx_full,
    input logic rx_ovf
);
    // R4
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |=> !rx_irq);

    // R4
    irq_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> rx_full);

    // R5
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ovf |=> rx_ovf);

    // R6
    stretch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_oe && !scl_rel) |=> scl_oe);

    // R7
    sda_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !$past(scl_i));
endmodule

bind i2c_tgt_core i2c_tgt_core_chk chk_i (.*);

// File: tb/i2c_tgt_core_tb.sv
module i2c_tgt_core_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int Q = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1, m_sda = 1'b1;
    logic scl_line, sda_line;
    logic scl_oe, sda_oe;
    logic [9:0] own_addr = '0;
    logic ten_bit_en = 1'b0;
    logic [7:0] tx_byte = '0;
    logic scl_rel = 1'b0, rx_rd = 1'b0;
    logic [7:0] rx_data;
    logic rx_irq, rx_full, rx_ovf, addr10_hit, tx_mode;

    int checks = 0;
    int errors = 0;
    int irq_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign scl_line = m_scl & ~scl_oe;
    assign sda_line = m_sda & ~sda_oe;

    always @(negedge clk) if (rx_irq) irq_cnt++;

    i2c_tgt_core dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .own_addr(own_addr),
        .ten_bit_en(ten_bit_en), .tx_byte(tx_byte), .scl_rel(scl_rel),
        .rx_rd(rx_rd), .rx_data(rx_data), .rx_irq(rx_irq), .rx_full(rx_full),
        .rx_ovf(rx_ovf), .addr10_hit(addr10_hit), .tx_mode(tx_mode)
    );

    // {ten, own[9:0], addr byte, data byte, expected ACK}
    localparam logic [27:0] VEC [6] = '{
        {1'b0, 10'h02A, 8'h54, 8'hA5, 1'b1},
        {1'b0, 10'h02A, 8'h56, 8'h3C, 1'b0},
        {1'b0, 10'h07F, 8'hFE, 8'h00, 1'b1},
        {1'b0, 10'h000, 8'h00, 8'hFF, 1'b1},
        {1'b1, 10'h02A, 8'h54, 8'h11, 1'b0},
        {1'b0, 10'h3D5, 8'hAA, 8'h81, 1'b1}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic scl_high();
        m_scl = 1'b1;
        while (!scl_line) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wq();
        scl_high(); wq();
        m_sda = 1'b0; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wq();
        scl_high(); wq();
        m_sda = 1'b1; wq();
    endtask

    task automatic clk_bit(input logic b, output logic r);
        m_sda = b; wq();
        scl_high(); wq();
        r = sda_line; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic write_byte(input logic [7:0] v, output logic acked);
        logic r;
        for (int i = 7; i >= 0; i--) clk_bit(v[i], r);
        clk_bit(1'b1, r);
        acked = !r;
    endtask

    task automatic read_byte(input logic give_ack, output logic [7:0] v);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, r);
            v[i] = r;
        end
        clk_bit(!give_ack, r);
    endtask

    task automatic pulse_rel();
        @(negedge clk) scl_rel = 1'b1;
        @(negedge clk) scl_rel = 1'b0;
    endtask

    task automatic pulse_rd();
        @(negedge clk) rx_rd = 1'b1;
        @(negedge clk) rx_rd = 1'b0;
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        report();
    end

    initial begin
        logic ak;
        logic [7:0] rb;
        int irq0;

        repeat (4) @(negedge clk);
        // R1 reset state
        chk("R1 scl_oe", scl_oe, 0);
        chk("R1 sda_oe", sda_oe, 0);
        chk("R1 flags", {rx_irq, rx_full, rx_ovf, addr10_hit, tx_mode}, 0);
        rst_n = 1'b1;
        wq();
        chk("R1 after release", {scl_oe, sda_oe, rx_full, rx_ovf, tx_mode}, 0);

        // R2/R4/R6 table of 7-bit writes
        foreach (VEC[k]) begin
            ten_bit_en = VEC[k][27];
            own_addr   = VEC[k][26:17];
            irq0       = irq_cnt;
            bus_start();
            write_byte(VEC[k][16:9], ak);
            chk($sformatf("R2 addr ack vec%0d", k), ak, VEC[k][0]);
            write_byte(VEC[k][8:1], ak);
            if (VEC[k][0]) begin
                chk($sformatf("R4 data ack vec%0d", k), ak, 1);
                wq();
                chk($sformatf("R6 stretch vec%0d", k), scl_oe, 1);
                chk($sformatf("R4 rx_data vec%0d", k), rx_data, VEC[k][8:1]);
                chk($sformatf("R4 irq count vec%0d", k), irq_cnt - irq0, 1);
                chk($sformatf("R4 rx_full vec%0d", k), rx_full, 1);
                pulse_rd();
                chk($sformatf("R4 rx_rd clears vec%0d", k), rx_full, 0);
                wq();
                chk($sformatf("R6 still held vec%0d", k), scl_oe, 1);
                pulse_rel();
                chk($sformatf("R6 released vec%0d", k), scl_oe, 0);
            end else begin
                chk($sformatf("R2 data ignored ack vec%0d", k), ak, 0);
                chk($sformatf("R2 data ignored irq vec%0d", k), irq_cnt - irq0, 0);
                chk($sformatf("R2 data ignored full vec%0d", k), rx_full, 0);
            end
            bus_stop();
        end

        // R3 10-bit write, then R5 overflow, then R8 read
        ten_bit_en = 1'b1;
        own_addr   = 10'h2C5;
        bus_start();
        write_byte(8'hF4, ak);
        chk("R3 header ack", ak, 1);
        chk("R3 flag not yet", addr10_hit, 0);
        write_byte(8'hC5, ak);
        chk("R3 low byte ack", ak, 1);
        chk("R3 addr10_hit", addr10_hit, 1);
        irq0 = irq_cnt;
        write_byte(8'h5A, ak);
        chk("R4 10-bit data ack", ak, 1);
        chk("R4 10-bit rx_data", rx_data, 8'h5A);
        pulse_rel();
        write_byte(8'h77, ak);
        chk("R5 byte still acked", ak, 1);
        chk("R5 ovf set", rx_ovf, 1);
        chk("R5 buffer kept", rx_data, 8'h5A);
        chk("R5 no extra irq", irq_cnt - irq0, 1);
        pulse_rel();
        bus_start();
        write_byte(8'hF5, ak);
        chk("R8 read header ack", ak, 1);
        wq();
        chk("R8 tx_mode", tx_mode, 1);
        chk("R6 stretch before read", scl_oe, 1);
        tx_byte = 8'hB3;
        pulse_rel();
        read_byte(1'b1, rb);
        chk("R8 first read byte", rb, 8'hB3);
        wq();
        chk("R6 stretch between reads", scl_oe, 1);
        tx_byte = 8'h4E;
        pulse_rel();
        read_byte(1'b0, rb);
        chk("R7 second read byte", rb, 8'h4E);
        wq();
        chk("R9 sda released", sda_oe, 0);
        chk("R9 tx_mode cleared", tx_mode, 0);
        chk("R10 flag before stop", addr10_hit, 1);
        bus_stop();
        chk("R10 addr10 cleared", addr10_hit, 0);
        chk("R10 lines released", {scl_oe, sda_oe}, 0);
        chk("R5 ovf sticky", rx_ovf, 1);

        // R8 read header without a prior full match
        bus_start();
        write_byte(8'hF5, ak);
        chk("R8 unmatched read header nack", ak, 0);
        bus_stop();

        // R3 bad low byte
        bus_start();
        write_byte(8'hF4, ak);
        chk("R3 header ack again", ak, 1);
        write_byte(8'hC4, ak);
        chk("R3 bad low byte nack", ak, 0);
        chk("R3 flag stays low", addr10_hit, 0);
        bus_stop();

        // R7 7-bit read, then R9 traffic after NACK is ignored
        ten_bit_en = 1'b0;
        own_addr   = 10'h031;
        pulse_rd();
        bus_start();
        write_byte(8'h63, ak);
        chk("R7 read addr ack", ak, 1);
        wq();
        chk("R7 tx_mode", tx_mode, 1);
        chk("R6 stretch on read", scl_oe, 1);
        tx_byte = 8'h96;
        pulse_rel();
        read_byte(1'b0, rb);
        chk("R7 read byte", rb, 8'h96);
        irq0 = irq_cnt;
        write_byte(8'h62, ak);
        chk("R9 ignored after nack", ak, 0);
        chk("R9 no irq after nack", irq_cnt - irq0, 0);
        chk("R9 no stretch after nack", scl_oe, 0);
        bus_stop();
        chk("R10 tx_mode after stop", tx_mode, 0);

        report();
    end
endmodule